// File: doc/BRIEF.md
# ASCII Command to Wishbone Bridge

This block sits behind a UART receiver and turns typed text into bus cycles. It takes one received character per `rx_valid_i` strobe. It recognises two commands: a write, which carries an address and a data word, and a read, which carries an address only. Each field is hexadecimal text, and single spaces separate the fields. For each complete command the block runs exactly one Wishbone master cycle. It then answers on a byte stream meant for a UART transmitter.

After reset the block first sends a short banner. It ignores incoming characters until that banner has been fully accepted. After a command it ignores input again until the bus cycle has ended and its reply has been fully handed off. Only one transaction is therefore ever outstanding. A malformed command is dropped without any reply, and the parser waits for the next command letter.

Top module: `ascii_wb_bridge`

## Requirements
- R1: After reset the reply stream carries the bytes 0x52 0x45 0x41 0x44 0x59 0x0D 0x0A ("READY", CR, LF). Characters received before the last of these bytes is accepted are ignored and start no bus cycle.
- R2: The sequence 'W' (0x57), space (0x20), four hex address digits, space, four hex data digits, space produces one Wishbone write (`wb_we_o`=1) with that address and data. The first digit is the most significant nibble.
- R3: The sequence 'R' (0x52), space, four hex address digits, space produces one Wishbone read (`wb_we_o`=0) at that address.
- R4: Hex digits 0-9, A-F and a-f are all accepted, and a lower-case letter has the same value as its upper-case form.
- R5: The whole command is dropped with no bus cycle and no reply when any of these occurs: a character other than a hex digit where a digit is expected, a character other than a space where a space is expected, or a space arriving early. The parser returns to idle, where any character other than 'W' or 'R' is ignored. A later well-formed command runs normally.
- R6: `wb_cyc_o` and `wb_stb_o` rise together and stay high until the cycle in which `wb_ack_i` is sampled high. `wb_adr_o`, `wb_we_o` and `wb_dat_o` stay stable throughout.
- R7: While a bus cycle or its reply is in progress, received characters are ignored.
- R8: A read replies with the four upper-case hex digits of the returned data, most significant first, then 0x0D 0x0A.
- R9: A write replies with 0x0D 0x0A only.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` stays stable.
- R11: `rst_ni` low asynchronously clears the parser and bus state. During reset, `wb_cyc_o` and `wb_stb_o` are 0, `tx_valid_o` is 1 and `tx_data_o` is 0x52.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received character |
| rx_valid_i | input | 1 | One-cycle strobe marking a received character |
| tx_data_o | output | 8 | Reply character |
| tx_valid_o | output | 1 | Reply character is available |
| tx_ready_i | input | 1 | Transmitter takes the reply character |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | 16 | Bus address |
| wb_dat_o | output | 16 | Write data |
| wb_dat_i | input | 16 | Read data |
| wb_ack_i | input | 1 | Slave acknowledge |

## Verification
The bench builds the bridge with its default 16-bit address and 16-bit data widths, so every command has exactly four digits per field. At this size, lower-case digits, the mix of letters and numerals, and data values with all nibbles at 0 or F fit into short strings. The bench slave can stretch the acknowledge and hold back `tx_ready_i`. This places characters inside the banner, inside a bus cycle and inside a stalled reply, so the drop rules and output stability are exercised there.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam logic [7:0] CH_SP = 8'h20;
  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;
  localparam logic [7:0] CH_WR = 8'h57;
  localparam logic [7:0] CH_RD = 8'h52;

  typedef enum logic [1:0] {RP_BANNER, RP_READ, RP_WRITE} reply_kind_e;

  typedef enum logic [3:0] {
    PS_BOOT, PS_IDLE, PS_SEP1, PS_ADR, PS_SEP2, PS_DAT, PS_SEP3, PS_ISSUE, PS_WAIT
  } parse_st_e;

  function automatic logic is_hex(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46) ||
           (c >= 8'h61 && c <= 8'h66);
  endfunction

  function automatic logic [3:0] hex_val(input logic [7:0] c);
    logic [7:0] t;
    if (c <= 8'h39)      t = c - 8'h30;
    else if (c <= 8'h46) t = c - 8'h37;
    else                 t = c - 8'h57;
    return t[3:0];
  endfunction

  function automatic logic [7:0] hex_chr(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  function automatic logic [7:0] banner_chr(input int i);
    case (i)
      0: return 8'h52;
      1: return 8'h45;
      2: return 8'h41;
      3: return 8'h44;
      4: return 8'h59;
      5: return CH_CR;
      default: return CH_LF;
    endcase
  endfunction
endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  input  logic              resume_i,
  output logic              cmd_valid_o,
  output logic              cmd_we_o,
  output logic [ADDR_W-1:0] cmd_adr_o,
  output logic [DATA_W-1:0] cmd_dat_o
);
  localparam int ADR_DIG = ADDR_W / 4;
  localparam int DAT_DIG = DATA_W / 4;
  localparam int MAX_DIG = (ADR_DIG > DAT_DIG) ? ADR_DIG : DAT_DIG;
  localparam int CNT_W   = $clog2(MAX_DIG + 1);

  parse_st_e         state_q;
  logic              we_q;
  logic [ADDR_W-1:0] adr_q;
  logic [DATA_W-1:0] dat_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        c;

  assign c = rx_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_BOOT;
      we_q    <= 1'b0;
      adr_q   <= '0;
      dat_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        PS_BOOT, PS_WAIT: if (resume_i) state_q <= PS_IDLE;
        PS_ISSUE:         state_q <= PS_WAIT;
        default: if (rx_valid_i) begin
          case (state_q)
            PS_IDLE: if (c == CH_WR || c == CH_RD) begin
              we_q    <= (c == CH_WR);
              state_q <= PS_SEP1;
            end
            PS_SEP1: begin
              cnt_q   <= '0;
              state_q <= (c == CH_SP) ? PS_ADR : PS_IDLE;
            end
            PS_ADR: if (is_hex(c)) begin
              adr_q <= {adr_q[ADDR_W-5:0], hex_val(c)};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CNT_W'(ADR_DIG - 1)) state_q <= PS_SEP2;
            end else state_q <= PS_IDLE;
            PS_SEP2: begin
              cnt_q <= '0;
              if (c != CH_SP) state_q <= PS_IDLE;
              else            state_q <= we_q ? PS_DAT : PS_ISSUE;
            end
            PS_DAT: if (is_hex(c)) begin
              dat_q <= {dat_q[DATA_W-5:0], hex_val(c)};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CNT_W'(DAT_DIG - 1)) state_q <= PS_SEP3;
            end else state_q <= PS_IDLE;
            PS_SEP3: state_q <= (c == CH_SP) ? PS_ISSUE : PS_IDLE;
            default: state_q <= PS_IDLE;
          endcase
        end
      endcase
    end
  end

  assign cmd_valid_o = (state_q == PS_ISSUE);
  assign cmd_we_o    = we_q;
  assign cmd_adr_o   = adr_q;
  assign cmd_dat_o   = dat_q;

  // one cycle per command
  p_issue_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  // input ignored while waiting on the transaction
  p_wait_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_WAIT && !resume_i) |=> (state_q == PS_WAIT));
endmodule

// File: rtl/wb_master.sv
module wb_master #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_we_i,
  input  logic [ADDR_W-1:0] cmd_adr_i,
  input  logic [DATA_W-1:0] cmd_dat_i,
  output logic              done_o,
  output logic              done_rd_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [DATA_W-1:0] wb_dat_o,
  input  logic [DATA_W-1:0] wb_dat_i,
  input  logic              wb_ack_i
);
  logic              cyc_q, we_q, done_q, rd_q;
  logic [ADDR_W-1:0] adr_q;
  logic [DATA_W-1:0] dat_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= 1'b0;
      we_q    <= 1'b0;
      adr_q   <= '0;
      dat_q   <= '0;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!cyc_q) begin
        if (cmd_valid_i) begin
          cyc_q <= 1'b1;
          we_q  <= cmd_we_i;
          adr_q <= cmd_adr_i;
          dat_q <= cmd_dat_i;
        end
      end else if (wb_ack_i) begin
        cyc_q  <= 1'b0;
        done_q <= 1'b1;
        rd_q   <= !we_q;
        if (!we_q) rdata_q <= wb_dat_i;
      end
    end
  end

  assign wb_cyc_o  = cyc_q;
  assign wb_stb_o  = cyc_q;
  assign wb_we_o   = we_q;
  assign wb_adr_o  = adr_q;
  assign wb_dat_o  = dat_q;
  assign done_o    = done_q;
  assign done_rd_o = rd_q;
  assign rdata_o   = rdata_q;

  p_hold_until_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q && !wb_ack_i) |=> cyc_q);
  p_fields_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q && !wb_ack_i) |=> ($stable(adr_q) && $stable(we_q) && $stable(dat_q)));
  p_no_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> !cyc_q);
endmodule

// File: rtl/reply_gen.sv
module reply_gen
  import bridge_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_rd_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              done_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  localparam int ND      = DATA_W / 4;
  localparam int LEN_BAN = 7;
  localparam int LEN_RD  = ND + 2;
  localparam int LEN_WR  = 2;
  localparam int MAXLEN  = (LEN_RD > LEN_BAN) ? LEN_RD : LEN_BAN;
  localparam int IDX_W   = $clog2(MAXLEN + 1);

  logic              active_q, done_q;
  reply_kind_e       kind_q;
  logic [IDX_W-1:0]  idx_q, last;
  logic [DATA_W-1:0] rbuf_q;
  logic [7:0]        chr;

  always_comb begin
    case (kind_q)
      RP_BANNER: last = IDX_W'(LEN_BAN - 1);
      RP_READ:   last = IDX_W'(LEN_RD - 1);
      default:   last = IDX_W'(LEN_WR - 1);
    endcase
  end

  always_comb begin
    logic [DATA_W-1:0] sh;
    int i;
    i   = int'(idx_q);
    sh  = '0;
    chr = CH_LF;
    case (kind_q)
      RP_BANNER: chr = banner_chr(i);
      RP_READ: begin
        if (i < ND) begin
          sh  = rbuf_q >> (4 * (ND - 1 - i));
          chr = hex_chr(sh[3:0]);
        end else if (i == ND) chr = CH_CR;
      end
      default: chr = (i == 0) ? CH_CR : CH_LF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      kind_q   <= RP_BANNER;
      idx_q    <= '0;
      rbuf_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (active_q) begin
        if (tx_ready_i) begin
          if (idx_q == last) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            done_q   <= 1'b1;
          end else idx_q <= idx_q + 1'b1;
        end
      end else if (start_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        kind_q   <= start_rd_i ? RP_READ : RP_WRITE;
        rbuf_q   <= rdata_i;
      end
    end
  end

  assign tx_valid_o = active_q;
  assign tx_data_o  = chr;
  assign done_o     = done_q;

  p_tx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
  p_start_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
endmodule

// File: rtl/ascii_wb_bridge.sv
module ascii_wb_bridge #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [DATA_W-1:0] wb_dat_o,
  input  logic [DATA_W-1:0] wb_dat_i,
  input  logic              wb_ack_i
);
  logic              cmd_valid, cmd_we, txn_done, txn_rd, reply_done;
  logic [ADDR_W-1:0] cmd_adr;
  logic [DATA_W-1:0] cmd_dat, txn_rdata;

  cmd_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parser (
    .clk_i, .rst_ni, .rx_data_i, .rx_valid_i,
    .resume_i   (reply_done),
    .cmd_valid_o(cmd_valid),
    .cmd_we_o   (cmd_we),
    .cmd_adr_o  (cmd_adr),
    .cmd_dat_o  (cmd_dat)
  );

  wb_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
    .clk_i, .rst_ni,
    .cmd_valid_i(cmd_valid),
    .cmd_we_i   (cmd_we),
    .cmd_adr_i  (cmd_adr),
    .cmd_dat_i  (cmd_dat),
    .done_o     (txn_done),
    .done_rd_o  (txn_rd),
    .rdata_o    (txn_rdata),
    .wb_cyc_o, .wb_stb_o, .wb_we_o, .wb_adr_o, .wb_dat_o, .wb_dat_i, .wb_ack_i
  );

  reply_gen #(.DATA_W(DATA_W)) u_reply (
    .clk_i, .rst_ni,
    .start_i   (txn_done),
    .start_rd_i(txn_rd),
    .rdata_i   (txn_rdata),
    .done_o    (reply_done),
    .tx_data_o, .tx_valid_o, .tx_ready_i
  );

  // no bus cycle while the banner is still going out
  p_banner_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !wb_cyc_o) |=> !wb_cyc_o);
endmodule

// File: tb/ascii_wb_bridge_bench.sv
`timescale 1ns/1ps
module ascii_wb_bridge_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  rx_data_i = 8'h00;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o;
  logic        tx_ready_i = 1'b0;
  logic        wb_cyc_o, wb_stb_o, wb_we_o;
  logic [15:0] wb_adr_o, wb_dat_o;
  logic [15:0] wb_dat_i = 16'h0;
  logic        wb_ack_i = 1'b0;

  ascii_wb_bridge u_ascii_wb_bridge (.*);

  always #2 clk_i = ~clk_i;

  int vectors = 0, miscompares = 0;
  bit hold_off = 1'b1;
  int slave_wait = 2;
  logic [15:0] slave_rdata = 16'h0;
  int txn_n = 0, wcnt = 0, cyc_ctr = 0;
  logic last_we;
  logic [15:0] last_adr, last_dat;
  logic [7:0] cap [0:255];
  int cap_n = 0;

  // reply sink with back-pressure, and slave model; decided at negedge for next posedge
  always @(negedge clk_i) begin
    bit rdy;
    cyc_ctr++;
    rdy = !hold_off && (cyc_ctr % 3 != 2);
    tx_ready_i = rdy;
    if (rst_ni && tx_valid_o && rdy && cap_n < 256) begin
      cap[cap_n] = tx_data_o;
      cap_n++;
    end
    wb_ack_i = 1'b0;
    if (rst_ni && wb_cyc_o && wb_stb_o) begin
      if (wcnt >= slave_wait) begin
        wb_ack_i = 1'b1;
        wb_dat_i = slave_rdata;
        last_we  = wb_we_o;
        last_adr = wb_adr_o;
        last_dat = wb_dat_o;
        txn_n++;
        wcnt = 0;
      end else wcnt++;
    end else wcnt = 0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk_i);
    rx_data_i  = b;
    rx_valid_i = 1'b1;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic send_hex(input logic [15:0] v, input bit lower);
    for (int i = 3; i >= 0; i--) begin
      logic [3:0] n;
      n = v[4*i +: 4];
      if (n < 10)   send_byte(8'h30 + 8'(n));
      else if (lower) send_byte(8'h57 + 8'(n));
      else          send_byte(8'h37 + 8'(n));
    end
  endtask

  task automatic wait_cap(input int n);
    for (int g = 0; g < 3000 && cap_n < n; g++) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  function automatic logic [7:0] up_hex(input logic [3:0] n);
    return (n < 10) ? 8'h30 + 8'(n) : 8'h37 + 8'(n);
  endfunction

  task automatic chk_reply(input int base, input bit rd, input logic [15:0] d, input string tag);
    logic [7:0] e [0:5];
    int len;
    if (rd) begin
      for (int i = 0; i < 4; i++) e[i] = up_hex(d[4*(3-i) +: 4]);
      e[4] = 8'h0D; e[5] = 8'h0A; len = 6;
    end else begin
      e[0] = 8'h0D; e[1] = 8'h0A; len = 2;
    end
    chk(cap_n == base + len, {tag, " reply length"}, 32'(cap_n - base), 32'(len));
    for (int i = 0; i < len; i++)
      chk(cap[base + i] == e[i], {tag, " reply byte"}, 32'(cap[base + i]), 32'(e[i]));
  endtask

  // {rd, lower, adr, dat, rdat}
  localparam logic [49:0] VEC [7] = '{
    {1'b0, 1'b0, 16'h0022, 16'h0002, 16'h0000},
    {1'b0, 1'b1, 16'hABCD, 16'h1234, 16'h0000},
    {1'b1, 1'b0, 16'h8006, 16'h0000, 16'hC5C0},
    {1'b1, 1'b1, 16'h00FF, 16'h0000, 16'hBEEF},
    {1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h0000},
    {1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0000},
    {1'b0, 1'b1, 16'h9A3F, 16'hE1B7, 16'h0000}
  };

  initial begin
    repeat (150000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int base, t0;
    logic [7:0] held;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(wb_cyc_o == 1'b0, "R11 cyc in reset", 32'(wb_cyc_o), 0);
    chk(wb_stb_o == 1'b0, "R11 stb in reset", 32'(wb_stb_o), 0);
    chk(tx_valid_o == 1'b1, "R11 tx_valid in reset", 32'(tx_valid_o), 1);
    chk(tx_data_o == 8'h52, "R11 tx_data in reset", 32'(tx_data_o), 32'h52);
    rst_ni = 1'b1;
    // R1 input during banner is dropped; R10 stall keeps first byte
    send_str("W 1234 5678 ");
    chk(tx_valid_o && tx_data_o == 8'h52, "R10 banner stalled", 32'(tx_data_o), 32'h52);
    hold_off = 1'b0;
    wait_cap(7);
    begin
      logic [7:0] bn [0:6] = '{8'h52, 8'h45, 8'h41, 8'h44, 8'h59, 8'h0D, 8'h0A};
      chk(cap_n == 7, "R1 banner length", 32'(cap_n), 7);
      for (int i = 0; i < 7; i++)
        chk(cap[i] == bn[i], "R1 banner byte", 32'(cap[i]), 32'(bn[i]));
    end
    chk(txn_n == 0, "R1 no cycle from early input", 32'(txn_n), 0);

    // table walk: R2 R3 R4 R8 R9
    for (int v = 0; v < 7; v++) begin
      logic rd, lo;
      logic [15:0] a, d, r;
      {rd, lo, a, d, r} = VEC[v];
      base = cap_n; t0 = txn_n; slave_rdata = r;
      send_byte(rd ? 8'h52 : 8'h57); send_byte(8'h20);
      send_hex(a, lo); send_byte(8'h20);
      if (!rd) begin send_hex(d, lo); send_byte(8'h20); end
      wait_cap(base + (rd ? 6 : 2));
      chk(txn_n == t0 + 1, rd ? "R3 one cycle" : "R2 one cycle", 32'(txn_n - t0), 1);
      chk(last_we == !rd, rd ? "R3 we" : "R2 we", 32'(last_we), 32'(!rd));
      chk(last_adr == a, lo ? "R4 address" : "R2 address", 32'(last_adr), 32'(a));
      if (!rd) chk(last_dat == d, lo ? "R4 data" : "R2 data", 32'(last_dat), 32'(d));
      chk_reply(base, rd, r, rd ? "R8" : "R9");
      repeat (3) @(negedge clk_i);
    end

    // R5 malformed commands
    base = cap_n; t0 = txn_n;
    send_str("W 12G4 5678 ");
    send_str("W 12 ");
    send_str("R 12345 ");
    send_str("X 1234 ");
    send_str("R 123 4 ");
    send_str("W 1234  ");
    repeat (10) @(negedge clk_i);
    chk(txn_n == t0, "R5 no cycle on malformed", 32'(txn_n - t0), 0);
    chk(cap_n == base, "R5 no reply on malformed", 32'(cap_n - base), 0);
    slave_rdata = 16'h7A01;
    send_str("R 4321 ");
    wait_cap(base + 6);
    chk(txn_n == t0 + 1, "R5 recovery cycle", 32'(txn_n - t0), 1);
    chk(last_adr == 16'h4321, "R5 recovery address", 32'(last_adr), 32'h4321);
    chk_reply(base, 1'b1, 16'h7A01, "R5");

    // R7 input during cycle and stalled reply; R6 long ack; R10 stall
    repeat (3) @(negedge clk_i);
    base = cap_n; t0 = txn_n;
    hold_off = 1'b1; slave_wait = 15; slave_rdata = 16'h3D9E;
    send_str("R 0abc ");
    send_str("W 5555 6666 ");
    repeat (4) @(negedge clk_i);
    held = tx_data_o;
    repeat (5) @(negedge clk_i);
    chk(tx_valid_o && tx_data_o == held, "R10 stalled reply stable", 32'(tx_data_o), 32'(held));
    chk(txn_n == t0 + 1, "R6 R7 single cycle", 32'(txn_n - t0), 1);
    chk(last_adr == 16'h0ABC && last_we == 1'b0, "R7 read address", 32'(last_adr), 32'h0ABC);
    hold_off = 1'b0;
    wait_cap(base + 6);
    chk_reply(base, 1'b1, 16'h3D9E, "R7");
    repeat (10) @(negedge clk_i);
    chk(txn_n == t0 + 1, "R7 no cycle after stall", 32'(txn_n - t0), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule